// File: doc/BRIEF.md
# Approximate Float Reciprocal Unit

This block computes an approximate reciprocal of a 16-bit floating-point word without using a divider. The word has three fields. Bit 15 is the sign. Bits 14:7 hold an 8-bit exponent with a bias of 127. Bits 6:0 hold a 7-bit fraction, and the leading one is implied. The datapath makes three changes to the word:

- The sign passes through unchanged.
- The fraction is replaced by an entry from a 128-entry table. The table is indexed by the input fraction and is built inside the design.
- The exponent is negated with one constant subtraction. The constant is one smaller when the fraction is nonzero, because the reciprocal of a mantissa strictly between 1 and 2 needs a one-place renormalisation.

The arithmetic is purely combinational. Data enters and leaves through valid/ready streams, with one register stage between them. A word is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high when the output register is empty or is being drained in that same cycle. A result stays on `out_data`, unchanged, for as long as `out_valid` is high and `out_ready` is low. Results leave in the order their inputs were accepted.

Top module: `recip_unit`

## Requirements
- R1: The output sign bit (bit 15) equals the input sign bit, unless the output is forced to 0x0000.
- R2: The output fraction (bits 6:0) is 0 for a zero input fraction T. For a nonzero T it is floor(32768/(128+T)) - 128.
- R3: For a zero input fraction, the output exponent (bits 14:7) is 254 - E, where E is the input exponent.
- R4: For a nonzero input fraction, the output exponent is 253 - E.
- R5: An input whose exponent field is 0 produces 0x0000. This includes 0x0000 and 0x8000.
- R6: If the exponent computed by R3 or R4 would be below 1, the output is 0x0000.
- R7: A word accepted at a clock edge appears with `out_valid` high right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Unit can take an input word this cycle |
| in_data | input | 16 | Operand: sign, exponent, fraction |
| out_valid | output | 1 | Result word is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Reciprocal result |

## Verification
The assertions assume the following about the inputs:

- `in_data` is meaningful only in cycles where `in_valid` and `in_ready` are both high.
- Reset is held long enough that the output register is empty when checking starts.

The stimulus covers the special cases that the exponent properties leave out: exponent 0, and exponents whose result would underflow. The stimulus drives inputs half a cycle away from the sampling edge. It varies `out_ready` in three patterns (always high, irregular, and mostly low), so the stall and hold properties are exercised with both back-to-back and stalled transfers.

// File: rtl/recip_pkg.sv
package recip_pkg;

  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 7;

  // Table entry: fraction of 2^(2F+1)/(2^F+t), i.e. mantissa of 1/(1+t/2^F)
  // renormalised one place; entry 0 is the exact case 1/1.
  function automatic int recip_entry(input int t, input int fw);
    int num;
    int den;
    if (t == 0) return 0;
    num = 1 << (2 * fw + 1);
    den = (1 << fw) + t;
    return (num / den) - (1 << fw);
  endfunction

endpackage

// File: rtl/recip_lut.sv
module recip_lut #(
  parameter int FRAC_W = recip_pkg::DEF_FRAC_W
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int ENTRIES = 1 << FRAC_W;

  logic [FRAC_W-1:0] rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign rom[g] = FRAC_W'(recip_pkg::recip_entry(g, FRAC_W));
  end

  assign frac_o = rom[frac_i];
endmodule

// File: rtl/recip_exp.sv
module recip_exp #(
  parameter int EXP_W = recip_pkg::DEF_EXP_W
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic             frac_nz_i,
  output logic [EXP_W-1:0] exp_o,
  output logic             zero_o
);
  localparam int DW         = EXP_W + 2;
  localparam int TWICE_BIAS = 2 * ((1 << (EXP_W - 1)) - 1);

  logic [DW-1:0] base;
  logic [DW-1:0] diff;

  always_comb begin
    base   = DW'(TWICE_BIAS);
    diff   = base - {{(DW-1){1'b0}}, frac_nz_i} - {2'b00, exp_i};
    exp_o  = diff[EXP_W-1:0];
    zero_o = (exp_i == '0) || diff[DW-1] || (diff == '0);
  end
endmodule

// File: rtl/recip_stage.sv
module recip_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign s_ready = !full_q || m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (s_ready) begin
      full_q <= s_valid;
      if (s_valid) data_q <= s_data;
    end
  end
endmodule

// File: rtl/recip_unit.sv
module recip_unit #(
  parameter int EXP_W  = recip_pkg::DEF_EXP_W,
  parameter int FRAC_W = recip_pkg::DEF_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EXP_W+FRAC_W:0]     in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W+FRAC_W:0]     out_data
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic              op_sign;
  logic [EXP_W-1:0]  op_exp;
  logic [FRAC_W-1:0] op_frac;
  logic [FRAC_W-1:0] res_frac;
  logic [EXP_W-1:0]  res_exp;
  logic              res_zero;
  logic [W-1:0]      res_word;

  assign op_sign = in_data[W-1];
  assign op_exp  = in_data[W-2:FRAC_W];
  assign op_frac = in_data[FRAC_W-1:0];

  recip_lut #(.FRAC_W(FRAC_W)) u_lut (
    .frac_i (op_frac),
    .frac_o (res_frac)
  );

  recip_exp #(.EXP_W(EXP_W)) u_exp (
    .exp_i     (op_exp),
    .frac_nz_i (|op_frac),
    .exp_o     (res_exp),
    .zero_o    (res_zero)
  );

  assign res_word = res_zero ? '0 : {op_sign, res_exp, res_frac};

  recip_stage #(.W(W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (res_word),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data)
  );
endmodule

// File: rtl/recip_unit_chk.sv
module recip_unit_chk #(
  parameter int EXP_W  = recip_pkg::DEF_EXP_W,
  parameter int FRAC_W = recip_pkg::DEF_FRAC_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_W+FRAC_W:0] in_data,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] out_data
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int TB = 2 * ((1 << (EXP_W - 1)) - 1);

  logic acc;
  int   in_e;
  int   out_e;
  logic fz;

  assign acc   = in_valid && in_ready;
  assign in_e  = int'(in_data[W-2:FRAC_W]);
  assign out_e = int'(out_data[W-2:FRAC_W]);
  assign fz    = (in_data[FRAC_W-1:0] == '0);

  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_data[W-1] == $past(in_data[W-1])) || (out_data == '0)); // R1

  AST_FRAC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && fz && in_e != 0 && in_e < TB |=> out_data[FRAC_W-1:0] == '0); // R2

  AST_EXP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && fz && in_e != 0 && in_e < TB |=> out_e == TB - $past(in_e)); // R3

  AST_EXP_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !fz && in_e != 0 && in_e < TB - 1 |=> out_e == TB - 1 - $past(in_e)); // R4

  AST_ZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_e == 0 |=> out_data == '0); // R5

  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ((fz && in_e >= TB) || (!fz && in_e >= TB - 1)) |=> out_data == '0); // R6

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
endmodule

bind recip_unit recip_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_recip_unit.sv
module tb_recip_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  recip_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [15:0] model(input logic [15:0] d);
    int e, t, ne, f;
    e = int'(d[14:7]);
    t = int'(d[6:0]);
    if (e == 0) return 16'h0000;                // R5
    ne = (t == 0) ? 254 - e : 253 - e;          // R3 / R4
    if (ne < 1) return 16'h0000;                // R6
    f = (t == 0) ? 0 : 32768 / (128 + t) - 128; // R2
    return {d[15], ne[7:0], f[6:0]};            // R1
  endfunction

  function automatic string tag(input logic [15:0] d);
    int e, t;
    e = int'(d[14:7]);
    t = int'(d[6:0]);
    if (e == 0) return "R5";
    if ((t == 0 && e >= 254) || (t != 0 && e >= 253)) return "R6";
    return (t == 0) ? "R1,R2,R3" : "R1,R2,R4";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] d);
    exp_q.push_back(model(d));
    tag_q.push_back(tag(d));
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    logic        stalled = 1'b0;
    logic [15:0] held = '0;
    forever begin
      @(negedge clk);
      cyc++;
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = cyc[0] ^ cyc[2];
        default: out_ready = (cyc % 5 == 0);
      endcase
      #1;
      if (rst_n) begin
        if (stalled) begin
          check("R8 hold valid", {15'd0, out_valid}, 16'd1);
          check("R8 hold data", out_data, held);
        end
        check("R8 in_ready rule", {15'd0, in_ready}, {15'd0, (!out_valid || out_ready)});
        stalled = out_valid && !out_ready;
        held    = out_data;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R7 unexpected output", out_data, 16'hxxxx);
          end else begin
            logic [15:0] e;
            string s;
            e = exp_q.pop_front();
            s = tag_q.pop_front();
            check(s, out_data, e);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 out_valid", {15'd0, out_valid}, 16'd0);
    check("R9 in_ready", {15'd0, in_ready}, 16'd1);

    // R7: single word, result valid right after accepting edge
    send(16'h4000);
    #1;
    check("R7 latency", {15'd0, out_valid}, 16'd1);
    idle();

    // Directed corner cases
    send(16'h4040);   // 3.0 -> 0x3EAA (R4)
    send(16'hC040);   // -3.0 -> 0xBEAA (R1)
    send(16'h3F80);   // 1.0 -> 1.0 (R3)
    send(16'h0000);   // R5
    send(16'h8000);   // R5, negative zero gives positive zero
    send(16'h0055);   // R5, zero exponent with fraction
    send(16'h7F00);   // R6, exponent 254 fraction 0
    send(16'h7F7F);   // R6
    send(16'h7E81);   // R6, exponent 253 nonzero fraction
    send(16'h7E80);   // R3 smallest result exponent 1
    send(16'h0080);   // R3 largest result
    send(16'h0081);   // R4
    idle();

    // Full fraction sweep under irregular back-pressure (R2)
    ready_mode = 1;
    for (int t = 0; t < 128; t++) send({1'b0, 8'd127, t[6:0]});
    idle();

    // Pseudo-random words under heavy back-pressure
    ready_mode = 2;
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        send(lf);
      end
    end
    idle();

    ready_mode = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule